// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block decides when a DRAM row refresh must happen and which row it applies to. Its aim is that every row is refreshed at least once per retention period (64 ms in the usual case). A free-running interval timer produces refresh events. An owed-refresh counter keeps those events while the memory controller is busy. A row counter names the next row to refresh.

The controller sees a request line and answers with a grant. A refresh takes place in each cycle where both are high. In that cycle a strobe is raised and the row address is valid. Two operating modes are available:

- **Spread mode:** one row is owed per interval. The interval is the retention period divided by the row count, for example 780 cycles at 100 MHz for 8192 rows.
- **Burst mode:** all rows are owed together once per period, and they are refreshed on back-to-back granted cycles.

Two external overrides are available. An external periodic pulse, such as a video blanking event, can replace the internal timer. A row address supplied from outside can replace the internal row counter.

Top module: `refresh_sched`

## Requirements
- R1: `rst_n` low asynchronously forces request, strobe, row address, owed count and overflow to zero. Reset release is synchronized through two flops.
- R2: In spread mode with the internal timer, one refresh becomes owed every `INTERVAL_CYC` cycles. The first request appears `INTERVAL_CYC`+2 cycles after `rst_n` rises.
- R3: `ref_req_o` is high while any refresh is owed. `ref_stb_o` is high in exactly the cycles where `ref_req_o` and `ref_gnt_i` are both high. A grant with no request changes nothing.
- R4: In spread mode each strobe lowers the owed count by one. When an interval event and a strobe fall in the same cycle, the count is unchanged.
- R5: The internal row counter steps by one on each strobe and wraps from `ROWS`-1 to 0. `ref_row_o` shows the counter.
- R6: The owed count saturates at `PEND_MAX`. An interval event that arrives while the count is full sets `pend_ovf_o`. The count stays at the limit, and the flag stays set until reset.
- R7: In burst mode (`burst_mode_i`=1), a period event occurs every `ROWS` intervals. Each period event owes `ROWS` refreshes, which are served on consecutive granted cycles in row order. The spread owed count is not incremented in this mode.
- R8: A period event that arrives while burst rows are still owed sets `pend_ovf_o`.
- R9: With `ext_tick_en_i`=1 the internal timer is held. Each cycle with `ext_tick_i` high counts as one event: an interval event in spread mode, a period event in burst mode.
- R10: With `ext_row_en_i`=1, `ref_row_o` equals `ext_row_i`, and strobes do not advance the internal row counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode_i | input | 1 | 1 = all rows once per period, 0 = one row per interval |
| ext_tick_en_i | input | 1 | Use the external pulse instead of the internal timer |
| ext_tick_i | input | 1 | External event pulse |
| ext_row_en_i | input | 1 | Use the external row address |
| ext_row_i | input | $clog2(ROWS) | External row address |
| ref_gnt_i | input | 1 | Controller grants the pending refresh |
| ref_req_o | output | 1 | A refresh is owed |
| ref_stb_o | output | 1 | Refresh issued this cycle |
| ref_row_o | output | $clog2(ROWS) | Row to refresh |
| pend_cnt_o | output | $clog2(PEND_MAX+1) | Owed refreshes in spread mode |
| pend_ovf_o | output | 1 | Sticky overflow of owed refreshes |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Interval event and strobe in the same cycle.** A design that lets one update override the other would drift the owed count.
- **Row counter wrap.** A wrong wrap would skip row 0 or run past the last row.
- **Grant with nothing owed.** A design that acts on it would issue a spurious refresh or underflow the counter.
- **Overflow at the saturation limit.** An off-by-one would flag early or let the count wrap to zero.
- **Burst reload while rows are still owed.** A design that misses this would silently lose rows.
- **External row override.** The internal counter must stay still under it. A design that lets it run would skip rows once the override is released.
- **External tick source.** The internal timer must be fully held, so no refresh is owed without a pulse.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  // Event pair from the tick generator.
  typedef struct packed {
    logic interval;  // one row becomes owed (spread mode)
    logic period;    // all rows become owed (burst mode)
  } rs_evt_t;
endpackage

// File: rtl/rs_rst_sync.sv
module rs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/rs_tick_gen.sv
module rs_tick_gen
  import refresh_sched_pkg::*;
#(
  parameter int INTERVAL_CYC = 780,
  parameter int ROWS         = 8192
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ext_en,
  input  logic    ext_tick,
  output rs_evt_t evt
);
  localparam int TMR_W = $clog2(INTERVAL_CYC);
  localparam int IDX_W = $clog2(ROWS);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(INTERVAL_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROWS - 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wrap;

  always_comb begin
    wrap  = !ext_en && (tmr_q == TMR_LAST);
    tmr_d = tmr_q;
    idx_d = idx_q;
    if (ext_en) begin
      tmr_d = '0;
      idx_d = '0;
    end else if (wrap) begin
      tmr_d = '0;
      idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
    evt.interval = ext_en ? ext_tick : wrap;
    evt.period   = ext_en ? ext_tick : (wrap && (idx_q == IDX_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      idx_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/rs_owed_tracker.sv
module rs_owed_tracker
  import refresh_sched_pkg::*;
#(
  parameter int ROWS     = 8192,
  parameter int PEND_MAX = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            burst_mode,
  input  rs_evt_t                         evt,
  input  logic                            stb,
  output logic                            req,
  output logic [$clog2(PEND_MAX+1)-1:0]   pend,
  output logic                            ovf
);
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam int BRST_W = $clog2(ROWS) + 1;
  localparam logic [PEND_W-1:0] PEND_FULL = PEND_W'(PEND_MAX);
  localparam logic [BRST_W-1:0] BRST_LOAD = BRST_W'(ROWS);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic [BRST_W-1:0] brst_q, brst_d;
  logic              ovf_q, ovf_d;
  logic              brst_act, pend_add, pend_sub, brst_sub;

  always_comb begin
    brst_act = (brst_q != '0);
    pend_add = !burst_mode && evt.interval;
    pend_sub = stb && !brst_act;
    brst_sub = stb && brst_act;
    pend_d   = pend_q;
    brst_d   = brst_q;
    ovf_d    = ovf_q;

    if (pend_add && !pend_sub) begin
      if (pend_q == PEND_FULL) ovf_d  = 1'b1;
      else                     pend_d = pend_q + 1'b1;
    end else if (pend_sub && !pend_add) begin
      pend_d = pend_q - 1'b1;
    end

    if (burst_mode && evt.period) begin
      brst_d = BRST_LOAD;
      if (brst_q > BRST_W'(brst_sub)) ovf_d = 1'b1;
    end else if (brst_sub) begin
      brst_d = brst_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      brst_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      brst_q <= brst_d;
      ovf_q  <= ovf_d;
    end
  end

  assign req  = (pend_q != '0) || brst_act;
  assign pend = pend_q;
  assign ovf  = ovf_q;
endmodule

// File: rtl/rs_row_ctr.sv
module rs_row_ctr #(
  parameter int ROWS = 8192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (adv) row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int ROWS         = 8192,
  parameter int INTERVAL_CYC = 780,
  parameter int PEND_MAX     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            burst_mode_i,
  input  logic                            ext_tick_en_i,
  input  logic                            ext_tick_i,
  input  logic                            ext_row_en_i,
  input  logic [$clog2(ROWS)-1:0]         ext_row_i,
  input  logic                            ref_gnt_i,
  output logic                            ref_req_o,
  output logic                            ref_stb_o,
  output logic [$clog2(ROWS)-1:0]         ref_row_o,
  output logic [$clog2(PEND_MAX+1)-1:0]   pend_cnt_o,
  output logic                            pend_ovf_o
);
  localparam int ROW_W = $clog2(ROWS);

  logic             rst_n_s;
  rs_evt_t          evt;
  logic             req;
  logic             stb;
  logic [ROW_W-1:0] row_q;

  rs_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  rs_tick_gen #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .ROWS         (ROWS)
  ) i_tick_gen (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ext_en   (ext_tick_en_i),
    .ext_tick (ext_tick_i),
    .evt      (evt)
  );

  assign stb = req && ref_gnt_i;

  rs_owed_tracker #(
    .ROWS     (ROWS),
    .PEND_MAX (PEND_MAX)
  ) i_owed (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .burst_mode (burst_mode_i),
    .evt        (evt),
    .stb        (stb),
    .req        (req),
    .pend       (pend_cnt_o),
    .ovf        (pend_ovf_o)
  );

  rs_row_ctr #(
    .ROWS (ROWS)
  ) i_row (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (stb && !ext_row_en_i),
    .row   (row_q)
  );

  assign ref_req_o = req;
  assign ref_stb_o = stb;
  assign ref_row_o = ext_row_en_i ? ext_row_i : row_q;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int ROWS     = 8192,
  parameter int PEND_MAX = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ref_stb_o,
  input logic                          ext_row_en_i,
  input logic [$clog2(ROWS)-1:0]       row_q,
  input logic [$clog2(PEND_MAX+1)-1:0] pend_cnt_o,
  input logic                          pend_ovf_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb_o && !ext_row_en_i) |=>
      (row_q == (($past(row_q) == ROW_LAST) ? '0 : $past(row_q) + 1'b1)));

  a_r10_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_stb_o && ext_row_en_i) |=> $stable(row_q));

  a_r6_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_cnt_o) <= PEND_MAX);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ovf_o |=> pend_ovf_o);

  a_r2_pend_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (32'(pend_cnt_o) <= 32'($past(pend_cnt_o)) + 1));
endmodule

bind refresh_sched refresh_sched_chk #(
  .ROWS     (ROWS),
  .PEND_MAX (PEND_MAX)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_stb_o    (ref_stb_o),
  .ext_row_en_i (ext_row_en_i),
  .row_q        (row_q),
  .pend_cnt_o   (pend_cnt_o),
  .pend_ovf_o   (pend_ovf_o)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 4;
  localparam int INTV       = 4;
  localparam int PMAX       = 3;
  localparam int ROW_W      = $clog2(ROWS);
  localparam int PEND_W     = $clog2(PMAX + 1);

  // {gnt, exp_req, exp_stb, exp_row[1:0], exp_pend[1:0]}, one per cycle
  localparam int NVEC = 21;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_1_0_00_01, 7'b0_1_0_00_01, 7'b0_1_0_00_01, 7'b0_1_0_00_01,
    7'b0_1_0_00_10, 7'b1_1_1_00_10, 7'b1_1_1_01_01, 7'b1_0_0_10_00,
    7'b1_1_1_10_01, 7'b0_0_0_11_00, 7'b0_0_0_11_00, 7'b1_0_0_11_00,
    7'b1_1_1_11_01, 7'b0_0_0_00_00, 7'b0_0_0_00_00, 7'b0_0_0_00_00,
    7'b0_1_0_00_01, 7'b0_1_0_00_01, 7'b0_1_0_00_01, 7'b1_1_1_00_01,
    7'b0_1_0_01_01
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              burst_mode_i, ext_tick_en_i, ext_tick_i, ext_row_en_i, ref_gnt_i;
  logic [ROW_W-1:0]  ext_row_i;
  logic              ref_req_o, ref_stb_o, pend_ovf_o;
  logic [ROW_W-1:0]  ref_row_o;
  logic [PEND_W-1:0] pend_cnt_o;

  int checks   = 0;
  int failures = 0;
  int c_stag   = 0;
  int cnt      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched #(.ROWS(ROWS), .INTERVAL_CYC(INTV), .PEND_MAX(PMAX)) i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .burst_mode_i(burst_mode_i),
    .ext_tick_en_i(ext_tick_en_i), .ext_tick_i(ext_tick_i),
    .ext_row_en_i(ext_row_en_i), .ext_row_i(ext_row_i), .ref_gnt_i(ref_gnt_i),
    .ref_req_o(ref_req_o), .ref_stb_o(ref_stb_o), .ref_row_o(ref_row_o),
    .pend_cnt_o(pend_cnt_o), .pend_ovf_o(pend_ovf_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Reset, check the reset state, release, count cycles to the first request.
  task automatic do_reset(input logic burst, input logic ext_t, output int n);
    rst_n = 1'b0; burst_mode_i = burst; ext_tick_en_i = ext_t; ext_tick_i = 1'b0;
    ext_row_en_i = 1'b0; ext_row_i = '0; ref_gnt_i = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check("R1 reset req", int'(ref_req_o), 0);
    check("R1 reset pend", int'(pend_cnt_o), 0);
    check("R1 reset ovf", int'(pend_ovf_o), 0);
    check("R1 reset row", int'(ref_row_o), 0);
    @(negedge clk); rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); n++;
      if (ref_req_o) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // Spread mode, vector walk (R2 R3 R4 R5)
    do_reset(1'b0, 1'b0, c_stag);
    check("R2 first request delay", c_stag, INTV + 2);
    for (int i = 0; i < NVEC; i++) begin
      ref_gnt_i = VEC[i][6]; #1;
      check($sformatf("R3 req v%0d", i), int'(ref_req_o), int'(VEC[i][5]));
      check($sformatf("R3 stb v%0d", i), int'(ref_stb_o), int'(VEC[i][4]));
      check($sformatf("R5 row v%0d", i), int'(ref_row_o), int'(VEC[i][3:2]));
      check($sformatf("R4 pend v%0d", i), int'(pend_cnt_o), int'(VEC[i][1:0]));
      @(negedge clk);
    end
    ref_gnt_i = 1'b0;

    // R10 external row address
    do_reset(1'b0, 1'b0, cnt);
    ext_row_en_i = 1'b1; ext_row_i = 2'd2; #1;
    check("R10 ext row shown", int'(ref_row_o), 2);
    ref_gnt_i = 1'b1; #1;
    check("R3 stb on grant", int'(ref_stb_o), 1);
    @(negedge clk);
    ref_gnt_i = 1'b0; ext_row_en_i = 1'b0; #1;
    check("R10 internal row held", int'(ref_row_o), 0);
    check("R4 pend after stb", int'(pend_cnt_o), 0);

    // R6 saturation and sticky overflow
    for (int k = 0; k < 40; k++) begin
      if (pend_cnt_o == PEND_W'(PMAX)) break;
      @(negedge clk);
    end
    #1;
    check("R6 pend reached max", int'(pend_cnt_o), PMAX);
    check("R6 no ovf at max", int'(pend_ovf_o), 0);
    repeat (INTV) @(negedge clk);
    #1;
    check("R6 ovf set", int'(pend_ovf_o), 1);
    check("R6 pend saturated", int'(pend_cnt_o), PMAX);
    ref_gnt_i = 1'b1; @(negedge clk); ref_gnt_i = 1'b0; #1;
    check("R6 ovf sticky", int'(pend_ovf_o), 1);
    check("R4 pend drop", int'(pend_cnt_o), PMAX - 1);

    // R7 burst mode with internal timer
    do_reset(1'b1, 1'b0, cnt);
    check("R7 burst period delay", cnt, c_stag + 3 * INTV);
    ref_gnt_i = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      #1;
      check($sformatf("R7 burst stb %0d", r), int'(ref_stb_o), 1);
      check($sformatf("R7 burst row %0d", r), int'(ref_row_o), r);
      check($sformatf("R7 burst pend %0d", r), int'(pend_cnt_o), 0);
      @(negedge clk);
    end
    #1;
    check("R7 burst done", int'(ref_req_o), 0);
    ref_gnt_i = 1'b0;

    // R9 + R8 burst with external pulse
    do_reset(1'b1, 1'b1, cnt);
    check("R9 timer held in burst", int'(ref_req_o), 0);
    ext_tick_i = 1'b1; @(negedge clk); ext_tick_i = 1'b0; #1;
    check("R9 pulse starts burst", int'(ref_req_o), 1);
    check("R8 no ovf yet", int'(pend_ovf_o), 0);
    ext_tick_i = 1'b1; @(negedge clk); ext_tick_i = 1'b0; #1;
    check("R8 burst ovf", int'(pend_ovf_o), 1);

    // R9 spread with external pulse
    do_reset(1'b0, 1'b1, cnt);
    check("R9 timer held spread", int'(pend_cnt_o), 0);
    ext_tick_i = 1'b1; @(negedge clk); ext_tick_i = 1'b0; #1;
    check("R9 pulse owes one", int'(pend_cnt_o), 1);

    // R1 asynchronous reset assertion
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 async req", int'(ref_req_o), 0);
    check("R1 async pend", int'(pend_cnt_o), 0);

    summary();
    $finish;
  end
endmodule